// File: doc/BRIEF.md
# Counter Bank Register Interface

This block is the byte-wide, memory-mapped front end of a bank of counter channels (five by default). A host reaches it through a 4-bit subaddress, an 8-bit write bus and a registered 8-bit read bus. The same subaddress names one register when written and a different one when read. The write side holds the setup words: function number, interrupt mask, master mode, counter mode, load value, hold value and alarm value. It also holds a one-byte command register. The read side returns interrupt information, error status and one result word per counter. Every 16-bit value crosses the bus as two bytes at neighbouring subaddresses.

The command byte carries a 3-bit operation code and a select mask with one bit per counter. Writing it executes the operation on every selected counter in a single cycle. The block pulses a per-counter strobe and shows the operation code, while the setup words stay on shared buses that every selected counter picks up. The save operation copies each selected counter's hold value into that counter's result register. The host can never read a hold value directly; it reads the result register instead. A read of a result low byte captures the whole 16-bit word, so the high byte read afterwards belongs to the same value. The counters themselves lie outside the block and appear only as ports.

Top module: `cbr_top`

## Requirements
- R1: After reset, all setup outputs, `rdata_o`, `ch_strobe_o` and `ch_op_o` are zero, and every result register and captured word is zero.
- R2: A write to subaddress 2k sets the high byte of setup word k, and a write to 2k+1 sets its low byte, for k = 0..6. The words are function number, interrupt mask, master mode, counter mode, load, hold and alarm, in that order. The new value appears on the matching output after the write's clock edge.
- R3: A write to subaddress 15 is the command byte: bits 7:5 are the operation code and bit i selects counter i. For codes 1 to 6, `ch_strobe_o` equals the select bits for exactly the one cycle after the write, and `ch_op_o` takes the code and holds it until the next command.
- R4: Command codes 0 (no operation) and 7 (reserved) leave `ch_strobe_o` at zero. `ch_op_o` still takes the code.
- R5: Code 5 (save) copies `cnt_hold_i` of each selected counter into that counter's result register on the edge of the command write. Counters that are not selected keep their result.
- R6: A read returns its byte on `rdata_o` one cycle after `rd_en_i`. Subaddresses 0 and 1 give the high and low bytes of `irq_info_i`, and 2 and 3 give those of `err_stat_i`. Subaddresses 4+2c and 5+2c give the high and low bytes of counter c's result. Subaddresses 14 and 15 read as zero.
- R7: A read of a result low byte captures the full 16-bit result. A later read of that counter's high byte returns the captured high byte, even if a save changed the result in between.
- R8: Reads never change a result register. Two low-byte reads with no save between them return the same byte.
- R9: A write to subaddress 14 has no effect: no setup output changes and no strobe occurs.
- R10: While `rd_en_i` is low, `rdata_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe |
| addr_i | input | 4 | Subaddress |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, registered |
| irq_info_i | input | 16 | Interrupt information word |
| err_stat_i | input | 16 | Error status word |
| cnt_hold_i | input | NUM_CNT*16 | Hold value of each counter, counter c in bits 16c+15:16c |
| fnum_o | output | 16 | Function number |
| int_mask_o | output | 16 | Interrupt mask |
| master_mode_o | output | 16 | Master mode word |
| cnt_mode_o | output | 16 | Counter mode word broadcast to selected counters |
| load_val_o | output | 16 | Load value broadcast |
| hold_val_o | output | 16 | Hold value broadcast |
| alarm_val_o | output | 16 | Alarm value broadcast |
| ch_strobe_o | output | NUM_CNT | One-cycle execute strobe per selected counter |
| ch_op_o | output | 3 | Operation code of the last command |

## Verification
The bench targets three risky spots. The first is the split between read and write maps: a design that reads back the write registers would return setup bytes where results or status belong. The second is the capture on a low-byte read. In the bench, a save lands between the low and high reads. A design that reads the high byte live would then return a torn word. The third is the handling of the no-operation and reserved codes, and of the unused subaddress 14. A careless decode would pulse the counters there, or corrupt a setup word. Unselected counters must keep their results across a save, and a strobe that lasts longer than one cycle is caught in the cycle after it should end.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_PARAM  = 3'd1,
    OP_ARM    = 3'd2,
    OP_DISARM = 3'd3,
    OP_LOAD   = 3'd4,
    OP_SAVE   = 3'd5,
    OP_STEP   = 3'd6,
    OP_RSVD   = 3'd7
  } op_e;

  localparam int          ADDR_W      = 4;
  localparam int          NUM_STG     = 7;
  localparam logic [3:0]  WA_CTRL_H   = 4'd14;
  localparam logic [3:0]  WA_CTRL_L   = 4'd15;
  localparam logic [3:0]  RA_INFO_H   = 4'd0;
  localparam logic [3:0]  RA_INFO_L   = 4'd1;
  localparam logic [3:0]  RA_ERR_H    = 4'd2;
  localparam logic [3:0]  RA_ERR_L    = 4'd3;
  localparam int          RA_RES_BASE = 4;

endpackage

// File: rtl/cbr_wr_regs.sv
module cbr_wr_regs
  import cbr_pkg::*;
#(
  parameter int NUM_CNT = 5,
  parameter int REG_W   = 16,
  localparam int BYTE_W = REG_W / 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [BYTE_W-1:0]               wdata_i,
  output logic [NUM_STG-1:0][REG_W-1:0]   stg_o,
  output logic [NUM_CNT-1:0]              strobe_o,
  output logic [2:0]                      op_o,
  output logic [NUM_CNT-1:0]              save_sel_o
);

  logic              ctrl_hit;
  logic              exec_ok;
  op_e               op_w;
  logic [NUM_CNT-1:0] sel_w;

  // setup words: high byte at even subaddress, low byte at odd
  for (genvar g = 0; g < NUM_STG; g++) begin : g_stg
    logic hi_hit, lo_hit;
    assign hi_hit = wr_en_i && (addr_i == ADDR_W'(2 * g));
    assign lo_hit = wr_en_i && (addr_i == ADDR_W'(2 * g + 1));

    always_ff @(posedge clk) begin
      if (rst) begin
        stg_o[g] <= '0;
      end else begin
        if (hi_hit) stg_o[g][REG_W-1:BYTE_W] <= wdata_i;
        if (lo_hit) stg_o[g][BYTE_W-1:0]     <= wdata_i;
      end
    end
  end

  assign ctrl_hit = wr_en_i && (addr_i == WA_CTRL_L);
  assign op_w     = op_e'(wdata_i[BYTE_W-1:BYTE_W-3]);
  assign sel_w    = wdata_i[NUM_CNT-1:0];
  assign exec_ok  = (op_w != OP_NOP) && (op_w != OP_RSVD);

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_o <= '0;
      op_o     <= '0;
    end else if (ctrl_hit) begin
      strobe_o <= exec_ok ? sel_w : '0;
      op_o     <= op_w;
    end else begin
      strobe_o <= '0;
    end
  end

  assign save_sel_o = (ctrl_hit && op_w == OP_SAVE) ? sel_w : '0;

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !ctrl_hit |=> strobe_o == '0); // R3

  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ctrl_hit && (wdata_i[BYTE_W-1:BYTE_W-3] == 3'd0 || wdata_i[BYTE_W-1:BYTE_W-3] == 3'd7))
      |=> strobe_o == '0); // R4

  AST_CTRL_HI_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == WA_CTRL_H) |=> $stable(stg_o)); // R9

endmodule

// File: rtl/cbr_result_bank.sv
module cbr_result_bank #(
  parameter int NUM_CNT = 5,
  parameter int REG_W   = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_CNT-1:0]              save_sel_i,
  input  logic [NUM_CNT-1:0][REG_W-1:0]   hold_i,
  input  logic [NUM_CNT-1:0]              snap_sel_i,
  output logic [NUM_CNT-1:0][REG_W-1:0]   res_o,
  output logic [NUM_CNT-1:0][REG_W-1:0]   snap_o
);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        res_o[g]  <= '0;
        snap_o[g] <= '0;
      end else begin
        if (save_sel_i[g]) res_o[g]  <= hold_i[g];
        if (snap_sel_i[g]) snap_o[g] <= res_o[g];
      end
    end

    AST_RES_KEPT: assert property (@(posedge clk) disable iff (rst)
      !save_sel_i[g] |=> $stable(res_o[g])); // R8

    AST_SNAP_WORD: assert property (@(posedge clk) disable iff (rst)
      snap_sel_i[g] |=> snap_o[g] == $past(res_o[g])); // R7
  end

endmodule

// File: rtl/cbr_rd_mux.sv
module cbr_rd_mux
  import cbr_pkg::*;
#(
  parameter int NUM_CNT = 5,
  parameter int REG_W   = 16,
  localparam int BYTE_W = REG_W / 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            rd_en_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [REG_W-1:0]                info_i,
  input  logic [REG_W-1:0]                err_i,
  input  logic [NUM_CNT-1:0][REG_W-1:0]   res_i,
  input  logic [NUM_CNT-1:0][REG_W-1:0]   snap_i,
  output logic [BYTE_W-1:0]               rdata_o,
  output logic [NUM_CNT-1:0]              snap_sel_o
);

  logic [BYTE_W-1:0] rd_next;

  always_comb begin
    rd_next    = '0;
    snap_sel_o = '0;
    unique case (addr_i)
      RA_INFO_H: rd_next = info_i[REG_W-1:BYTE_W];
      RA_INFO_L: rd_next = info_i[BYTE_W-1:0];
      RA_ERR_H:  rd_next = err_i[REG_W-1:BYTE_W];
      RA_ERR_L:  rd_next = err_i[BYTE_W-1:0];
      default: begin
        for (int c = 0; c < NUM_CNT; c++) begin
          if (addr_i == ADDR_W'(RA_RES_BASE + 2 * c)) begin
            rd_next = snap_i[c][REG_W-1:BYTE_W];
          end
          if (addr_i == ADDR_W'(RA_RES_BASE + 2 * c + 1)) begin
            rd_next       = res_i[c][BYTE_W-1:0];
            snap_sel_o[c] = rd_en_i;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_next;
  end

  AST_UNUSED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && addr_i >= 4'd14) |=> rdata_o == '0); // R6

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rdata_o)); // R10

endmodule

// File: rtl/cbr_top.sv
module cbr_top
  import cbr_pkg::*;
#(
  parameter int NUM_CNT = 5,
  parameter int REG_W   = 16,
  localparam int BYTE_W = REG_W / 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en_i,
  input  logic                        rd_en_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [BYTE_W-1:0]           wdata_i,
  output logic [BYTE_W-1:0]           rdata_o,
  input  logic [REG_W-1:0]            irq_info_i,
  input  logic [REG_W-1:0]            err_stat_i,
  input  logic [NUM_CNT*REG_W-1:0]    cnt_hold_i,
  output logic [REG_W-1:0]            fnum_o,
  output logic [REG_W-1:0]            int_mask_o,
  output logic [REG_W-1:0]            master_mode_o,
  output logic [REG_W-1:0]            cnt_mode_o,
  output logic [REG_W-1:0]            load_val_o,
  output logic [REG_W-1:0]            hold_val_o,
  output logic [REG_W-1:0]            alarm_val_o,
  output logic [NUM_CNT-1:0]          ch_strobe_o,
  output logic [2:0]                  ch_op_o
);

  logic [NUM_STG-1:0][REG_W-1:0] stg;
  logic [NUM_CNT-1:0][REG_W-1:0] hold_arr;
  logic [NUM_CNT-1:0][REG_W-1:0] res;
  logic [NUM_CNT-1:0][REG_W-1:0] snap;
  logic [NUM_CNT-1:0]            save_sel;
  logic [NUM_CNT-1:0]            snap_sel;

  assign hold_arr = cnt_hold_i;

  cbr_wr_regs #(.NUM_CNT(NUM_CNT), .REG_W(REG_W)) u_wr (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .stg_o      (stg),
    .strobe_o   (ch_strobe_o),
    .op_o       (ch_op_o),
    .save_sel_o (save_sel)
  );

  cbr_result_bank #(.NUM_CNT(NUM_CNT), .REG_W(REG_W)) u_res (
    .clk        (clk),
    .rst        (rst),
    .save_sel_i (save_sel),
    .hold_i     (hold_arr),
    .snap_sel_i (snap_sel),
    .res_o      (res),
    .snap_o     (snap)
  );

  cbr_rd_mux #(.NUM_CNT(NUM_CNT), .REG_W(REG_W)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .info_i     (irq_info_i),
    .err_i      (err_stat_i),
    .res_i      (res),
    .snap_i     (snap),
    .rdata_o    (rdata_o),
    .snap_sel_o (snap_sel)
  );

  assign fnum_o        = stg[0];
  assign int_mask_o    = stg[1];
  assign master_mode_o = stg[2];
  assign cnt_mode_o    = stg[3];
  assign load_val_o    = stg[4];
  assign hold_val_o    = stg[5];
  assign alarm_val_o   = stg[6];

  AST_SAVE_TAKES_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == WA_CTRL_L && wdata_i[7:5] == 3'd5 && wdata_i[0])
      |=> res[0] == $past(hold_arr[0])); // R5

endmodule

// File: tb/cbr_top_tb_top.sv
module cbr_top_tb_top;
  localparam int NC = 5;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en_i, rd_en_i;
  logic [3:0]  addr_i;
  logic [7:0]  wdata_i;
  logic [7:0]  rdata_o;
  logic [15:0] irq_info_i, err_stat_i;
  logic [NC*16-1:0] cnt_hold_i;
  logic [15:0] fnum_o, int_mask_o, master_mode_o, cnt_mode_o;
  logic [15:0] load_val_o, hold_val_o, alarm_val_o;
  logic [NC-1:0] ch_strobe_o;
  logic [2:0]  ch_op_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [15:0] m_stg [7];
  logic [15:0] m_res [NC];

  always #2 clk = ~clk;

  cbr_top #(.NUM_CNT(NC)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] stg_out(input int k);
    case (k)
      0: return fnum_o;
      1: return int_mask_o;
      2: return master_mode_o;
      3: return cnt_mode_o;
      4: return load_val_o;
      5: return hold_val_o;
      default: return alarm_val_o;
    endcase
  endfunction

  function automatic logic [NC-1:0] exp_strobe(input logic [2:0] op, input logic [NC-1:0] sel);
    return (op == 3'd0 || op == 3'd7) ? '0 : sel;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic check_stg(input string req);
    for (int k = 0; k < 7; k++) chk(req, stg_out(k), m_stg[k]);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    int unused;
    unused = $urandom(32'h5eed);
    rst = 1'b1; wr_en_i = 0; rd_en_i = 0; addr_i = 0; wdata_i = 0;
    irq_info_i = 16'hA55A; err_stat_i = 16'h3C01; cnt_hold_i = '0;
    for (int k = 0; k < 7; k++) m_stg[k] = '0;
    for (int c = 0; c < NC; c++) m_res[c] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check_stg("R1");
    chk("R1 strobe", ch_strobe_o, 0);
    chk("R1 op", ch_op_o, 0);
    chk("R1 rdata", rdata_o, 0);
    rd(4'd5, d); chk("R1 result", d, 0);

    // R2 random byte writes to setup words
    for (int i = 0; i < 40; i++) begin
      int k; logic hi; logic [7:0] b;
      k = $urandom_range(0, 6); hi = 1'($urandom); b = 8'($urandom);
      wr(4'(2 * k + (hi ? 0 : 1)), b);
      if (hi) m_stg[k][15:8] = b; else m_stg[k][7:0] = b;
      chk("R2", stg_out(k), m_stg[k]);
    end
    check_stg("R2");

    // R3 / R4 every operation code
    for (int op = 0; op < 8; op++) begin
      logic [NC-1:0] sel;
      sel = NC'($urandom) | NC'(1);
      if (op == 5) cnt_hold_i = '0;
      wr(4'd15, {3'(op), 5'(sel)});
      if (op == 5) for (int c = 0; c < NC; c++) if (sel[c]) m_res[c] = '0;
      chk((op == 0 || op == 7) ? "R4" : "R3", ch_strobe_o, exp_strobe(3'(op), sel));
      chk("R3 op", ch_op_o, op);
      @(negedge clk);
      chk("R3 one cycle", ch_strobe_o, 0);
      chk("R3 op held", ch_op_o, op);
    end

    // R9 high byte of command subaddress
    wr(4'd14, 8'hFF);
    chk("R9 strobe", ch_strobe_o, 0);
    check_stg("R9");

    // R5 / R6 random saves, then read every counter
    for (int i = 0; i < 12; i++) begin
      logic [NC-1:0] sel;
      for (int c = 0; c < NC; c++) cnt_hold_i[16*c +: 16] = 16'($urandom);
      sel = NC'($urandom);
      if (i == 0) sel = '1;
      wr(4'd15, {3'd5, 5'(sel)});
      for (int c = 0; c < NC; c++) if (sel[c]) m_res[c] = cnt_hold_i[16*c +: 16];
      for (int c = 0; c < NC; c++) begin
        rd(4'(5 + 2 * c), d);  chk("R5 lo", d, m_res[c][7:0]);
        rd(4'(4 + 2 * c), d);  chk("R6 hi", d, m_res[c][15:8]);
      end
    end

    // R8 repeated low reads
    rd(4'd7, d); rd(4'd7, d2); chk("R8", d2, d);
    chk("R8 value", d, m_res[1][7:0]);

    // R7 save between low and high read of counter 2
    rd(4'd9, d); chk("R7 lo", d, m_res[2][7:0]);
    cnt_hold_i[32 +: 16] = ~m_res[2];
    wr(4'd15, {3'd5, 5'b00100});
    rd(4'd8, d); chk("R7 hi captured", d, m_res[2][15:8]);
    m_res[2] = cnt_hold_i[32 +: 16];
    rd(4'd9, d); chk("R7 new lo", d, m_res[2][7:0]);
    rd(4'd8, d); chk("R7 new hi", d, m_res[2][15:8]);

    // R6 status and unused reads
    rd(4'd0, d); chk("R6 info hi", d, 8'hA5);
    rd(4'd1, d); chk("R6 info lo", d, 8'h5A);
    rd(4'd2, d); chk("R6 err hi", d, 8'h3C);
    rd(4'd3, d); chk("R6 err lo", d, 8'h01);
    rd(4'd14, d); chk("R6 sub14", d, 0);
    rd(4'd3, d);
    rd(4'd15, d); chk("R6 sub15", d, 0);

    // R10 idle bus keeps rdata
    rd(4'd0, d);
    repeat (3) @(negedge clk);
    chk("R10", rdata_o, 8'hA5);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule